// File: doc/BRIEF.md
# Write-in-Progress Status Read Logic

This block decides what a byte-wide memory returns on its read bus while a self-timed programming cycle is in progress. While the write controller reports busy, a read does not return array contents. It returns a status byte that carries two end-of-write indications. The top bit is the inverse of the top bit of the last byte written. The next bit flips on every new read access. When busy drops, every bit again carries true array data and the flipping bit stops moving.

The active-low strobes are sampled in the block's clock domain. A read exists while the chip select and output enable are low and the write strobe is high. A new read access begins on the cycle in which that condition becomes true. This happens whether chip select, output enable or both were released in between. The output bus and its drive enable are registered, so they follow the sampled strobes by one clock. While the drive enable is low, the data output is held at zero.

Top module: `wip_status_read`

## Requirements
- R1: `bus_drive` is 1 in the cycle after a cycle in which `chip_sel_n`=0, `out_en_n`=0 and `wr_strobe_n`=1 are sampled, and 0 in the cycle after any other combination.
- R2: Whenever `bus_drive` is 0, `bus_data` is 0. This stands for the high-impedance bus. After reset, both outputs are 0.
- R3: During a read with `wr_busy`=1, bit 7 of `bus_data` is the inverse of bit 7 of `last_wr_byte`.
- R4: With `wr_busy`=1, bit 6 of `bus_data` takes the opposite value at each new read access compared with the previous read access. The phase at the start of a write is undefined.
- R5: Within one continuous read, meaning the read condition is held over several cycles, bit 6 does not change.
- R6: During a read with `wr_busy`=0, `bus_data` equals `array_rdata` on all 8 bits, including bit 6 and bit 7.
- R7: Releasing only `out_en_n`, only `chip_sel_n`, or both between two reads each count as a new access for R4.
- R8: Cycles with `wr_strobe_n`=0 are not reads. They set `bus_drive` to 0 and do not advance the bit-6 alternation seen by the next read.
- R9: During a read with `wr_busy`=1, bits 5..0 of `bus_data` equal bits 5..0 of `last_wr_byte`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_sel_n | input | 1 | Chip select, active low |
| out_en_n | input | 1 | Output enable, active low |
| wr_strobe_n | input | 1 | Write strobe, active low |
| wr_busy | input | 1 | Programming cycle in progress, from the write controller |
| last_wr_byte | input | 8 | Last byte accepted by the write controller |
| array_rdata | input | 8 | Normal array read data |
| bus_data | output | 8 | Read data bus |
| bus_drive | output | 1 | Bus drive enable; 0 means high impedance |

## Verification
Reads are issued while busy with last-written bytes of both top-bit values, so an inverted poll bit can be told apart from a copied one. Reads are also issued with mixed low bits, which shows whether bits 5..0 pass through. Successive reads are separated by releasing the output enable alone, the chip select alone, or both, and each case must flip bit 6. A single long read must keep bit 6 steady, which separates edge detection from level detection. Write-strobe cycles placed between reads must neither drive the bus nor disturb the alternation. The same array data read with busy low, before and after a write, must come back unaltered on all bits.

// File: rtl/wsr_pkg.sv
package wsr_pkg;
  localparam int DATA_W   = 8;
  localparam int POLL_IDX = DATA_W - 1;
  localparam int TOG_IDX  = DATA_W - 2;

  // Read condition from active-low strobes.
  function automatic logic read_cond(input logic cs_n, input logic oe_n, input logic we_n);
    return (!cs_n) && (!oe_n) && we_n;
  endfunction

  // Status byte presented while a write is running.
  function automatic logic [DATA_W-1:0] status_word(input logic [DATA_W-1:0] last_b,
                                                    input logic tog);
    logic [DATA_W-1:0] s;
    s           = last_b;
    s[POLL_IDX] = ~last_b[POLL_IDX];
    s[TOG_IDX]  = tog;
    return s;
  endfunction
endpackage

// File: rtl/wsr_access_detect.sv
module wsr_access_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic oe_n,
  input  logic we_n,
  output logic rd_now,
  output logic access_start
);
  import wsr_pkg::*;
  logic rd_q;

  assign rd_now       = read_cond(cs_n, oe_n, we_n);
  assign access_start = rd_now && !rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= rd_now;
  end

  // An access start is never seen twice in a row (R5).
  assert_single_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    access_start |=> !access_start);
endmodule

// File: rtl/wsr_toggle_gen.sv
module wsr_toggle_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic access_start,
  input  logic busy,
  output logic tog_next,
  output logic tog_bit
);
  logic flip_ev;
  assign flip_ev  = access_start && busy;
  assign tog_next = tog_bit ^ flip_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_bit <= 1'b0;
    else        tog_bit <= tog_next;
  end

  assert_tog_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flip_ev |=> tog_bit != $past(tog_bit));
  assert_tog_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !access_start |=> $stable(tog_bit));
endmodule

// File: rtl/wsr_out_stage.sv
module wsr_out_stage
  import wsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_now,
  input  logic              busy,
  input  logic              tog_next,
  input  logic [DATA_W-1:0] last_b,
  input  logic [DATA_W-1:0] arr_d,
  output logic [DATA_W-1:0] dout,
  output logic              drive
);
  logic [DATA_W-1:0] sel_word;

  always_comb begin
    if (!rd_now)   sel_word = '0;
    else if (busy) sel_word = status_word(last_b, tog_next);
    else           sel_word = arr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout  <= '0;
      drive <= 1'b0;
    end else begin
      dout  <= sel_word;
      drive <= rd_now;
    end
  end

  assert_drive_on_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_now |=> drive);
  assert_drive_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_now |=> !drive);
  assert_quiet_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !drive |-> dout == '0);
  assert_poll_inv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_now && busy) |=> dout[POLL_IDX] == ~$past(last_b[POLL_IDX]));
  assert_low_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_now && busy) |=> dout[TOG_IDX-1:0] == $past(last_b[TOG_IDX-1:0]));
  assert_true_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_now && !busy) |=> dout == $past(arr_d));
endmodule

// File: rtl/wip_status_read.sv
module wip_status_read
  import wsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_sel_n,
  input  logic              out_en_n,
  input  logic              wr_strobe_n,
  input  logic              wr_busy,
  input  logic [DATA_W-1:0] last_wr_byte,
  input  logic [DATA_W-1:0] array_rdata,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_drive
);
  logic rd_now;
  logic access_start;
  logic tog_next;
  logic tog_bit;

  wsr_access_detect u_det (
    .clk(clk), .rst_n(rst_n), .cs_n(chip_sel_n), .oe_n(out_en_n), .we_n(wr_strobe_n),
    .rd_now(rd_now), .access_start(access_start)
  );

  wsr_toggle_gen u_tog (
    .clk(clk), .rst_n(rst_n), .access_start(access_start), .busy(wr_busy),
    .tog_next(tog_next), .tog_bit(tog_bit)
  );

  wsr_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .rd_now(rd_now), .busy(wr_busy), .tog_next(tog_next),
    .last_b(last_wr_byte), .arr_d(array_rdata), .dout(bus_data), .drive(bus_drive)
  );

  // Write-strobe cycles never drive the bus (R8).
  assert_no_drive_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_strobe_n |=> !bus_drive);
endmodule

// File: tb/wip_status_read_test.sv
module wip_status_read_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic       busy = 1'b0;
  logic [7:0] last_b = 8'h00, arr = 8'h00;
  logic [7:0] bus_data;
  logic       bus_drive;
  int checks = 0, errors = 0;
  logic prev6;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  wip_status_read uut (
    .clk(clk), .rst_n(rst_n), .chip_sel_n(cs_n), .out_en_n(oe_n), .wr_strobe_n(we_n),
    .wr_busy(busy), .last_wr_byte(last_b), .array_rdata(arr),
    .bus_data(bus_data), .bus_drive(bus_drive)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Inputs change at negedge; registered outputs are sampled at the next negedge.
  task automatic step;
    @(negedge clk);
  endtask

  // One read access of one cycle, then release according to mode:
  // 0 = output enable only, 1 = chip select only, 2 = both.
  task automatic do_read(input int mode, output logic [7:0] val);
    cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    step;
    chk(bus_drive === 1'b1, "R1 drive during read", bus_drive, 1);
    val = bus_data;
    if (mode == 0) oe_n = 1'b1;
    else if (mode == 1) cs_n = 1'b1;
    else begin cs_n = 1'b1; oe_n = 1'b1; end
    step;
    chk(bus_drive === 1'b0, "R1 release", bus_drive, 0);
    chk(bus_data === 8'h00, "R2 quiet bus", bus_data, 0);
    cs_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic t_reset;
    step;
    chk(bus_drive === 1'b0, "R2 reset drive", bus_drive, 0);
    chk(bus_data === 8'h00, "R2 reset data", bus_data, 0);
    rst_n = 1'b1;
    step;
  endtask

  task automatic t_idle_read;
    busy = 1'b0; arr = 8'hC5;
    do_read(2, rv);
    chk(rv === 8'hC5, "R6 true data C5", rv, 8'hC5);
    arr = 8'h3A;
    do_read(0, rv);
    chk(rv === 8'h3A, "R6 true data 3A", rv, 8'h3A);
  endtask

  task automatic t_poll;
    busy = 1'b1; last_b = 8'hA9; arr = 8'h00;
    do_read(2, rv);
    chk(rv[7] === 1'b0, "R3 inverted bit7 of A9", rv[7], 0);
    chk(rv[5:0] === 6'h29, "R9 low bits of A9", rv[5:0], 6'h29);
    prev6 = rv[6];
    last_b = 8'h16;
    do_read(2, rv);
    chk(rv[7] === 1'b1, "R3 inverted bit7 of 16", rv[7], 1);
    chk(rv[5:0] === 6'h16, "R9 low bits of 16", rv[5:0], 6'h16);
    chk(rv[6] === ~prev6, "R4 alternate", rv[6], ~prev6);
    prev6 = rv[6];
  endtask

  task automatic t_strobes;
    for (int m = 0; m < 3; m++) begin
      do_read(m, rv);
      chk(rv[6] === ~prev6, $sformatf("R7 release mode %0d", m), rv[6], ~prev6);
      prev6 = rv[6];
    end
  endtask

  task automatic t_hold;
    cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    step;
    chk(bus_data[6] === ~prev6, "R4 long read first", bus_data[6], ~prev6);
    prev6 = bus_data[6];
    for (int i = 0; i < 4; i++) begin
      step;
      chk(bus_data[6] === prev6, "R5 stable in long read", bus_data[6], prev6);
    end
    oe_n = 1'b1; step;
  endtask

  task automatic t_write_gap;
    cs_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
    step;
    chk(bus_drive === 1'b0, "R8 write cycle no drive", bus_drive, 0);
    oe_n = 1'b0;
    step;
    chk(bus_drive === 1'b0, "R8 oe low with write strobe", bus_drive, 0);
    oe_n = 1'b1; we_n = 1'b1; cs_n = 1'b1;
    step;
    do_read(2, rv);
    chk(rv[6] === ~prev6, "R8 alternation kept", rv[6], ~prev6);
    prev6 = rv[6];
  endtask

  task automatic t_complete;
    busy = 1'b0; arr = 8'h7E;
    do_read(2, rv);
    chk(rv === 8'h7E, "R6 after write done", rv, 8'h7E);
    do_read(1, rv);
    chk(rv === 8'h7E, "R6 bit6 stops toggling", rv, 8'h7E);
    arr = 8'hFF;
    do_read(0, rv);
    chk(rv === 8'hFF, "R6 all ones", rv, 8'hFF);
  endtask

  initial begin
    t_reset;
    t_idle_read;
    t_poll;
    t_strobes;
    t_hold;
    t_write_gap;
    t_complete;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule